// File: doc/BRIEF.md
# Cache Access Sequencer

This block steps a single CPU load or store through the cache array, main memory and a holding register for the line or word in flight. It accepts one request at a time. A load first probes the cache. On a hit it returns the data at once. On a miss it signals the coherence logic and waits for that logic to finish. It then fetches the line from memory into the holding register, writes the register into the cache, and probes the cache again, so that the original load completes as an ordinary hit.

A store captures its data in the holding register when the request is accepted. It writes memory first, then updates the cache from the register, and returns to idle. Memory accesses take at least `MEM_LAT` cycles and end only when the memory also reports that it is ready. The block produces only strobes and flags. The datapath and the coherence states belong to the surrounding logic.

Top module: `cache_seq_ctrl`

## Requirements
- R1: After reset every output is low: `busy`, `data_valid`, `read_miss`, `mem_rd_en`, `mem_wr_en`, `cache_wr_en` and `tmp_load`.
- R2: While idle, a request with `req_write`=0 moves the block to the cache probe on the next cycle. A request with `req_write`=1 pulses `tmp_load` in the accepting cycle and asserts `mem_wr_en` from the next cycle.
- R3: In a probe cycle with `cache_hit`=1, `data_valid` is high in that cycle and the block is idle (`busy`=0) in the next cycle.
- R4: In a probe cycle with `cache_hit`=0, `read_miss` is high. The block then asserts no memory enable until it has sampled `coh_done`=1. `mem_rd_en` rises in the cycle after that sample.
- R5: A memory access ends in the first cycle k (counted from 0 at the first enabled cycle) in which k >= `MEM_LAT`-1 and `mem_ready`=1. The enable stays high through that cycle and is low in the next one.
- R6: A memory read pulses `tmp_load` in its ending cycle, and `cache_wr_en` is high in the following cycle.
- R7: A memory write is followed by one `cache_wr_en` cycle without `tmp_load`, after which the block is idle. `data_valid` stays low even when `cache_hit` is high.
- R8: A cache fill that followed a miss returns the block to the probe, where a hit raises `data_valid`.
- R9: `req_valid` has no effect while `busy` is high. It causes no `tmp_load` outside a read's ending cycle and no `mem_wr_en` during a load.
- R10: `busy` is low exactly when the block is idle and high in every other cycle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = store, 0 = load |
| cache_hit | input | 1 | Cache tag match with a valid line |
| coh_done | input | 1 | Coherence handling of a miss finished |
| mem_ready | input | 1 | Memory can complete the current access |
| mem_rd_en | output | 1 | Main memory read enable |
| mem_wr_en | output | 1 | Main memory write enable |
| cache_wr_en | output | 1 | Cache array write enable |
| tmp_load | output | 1 | Load the holding register |
| read_miss | output | 1 | Probe missed; hand-off to coherence logic |
| busy | output | 1 | Transaction in progress |
| data_valid | output | 1 | Load data available from the cache |

## Verification
A wrong internal state shows at the ports within one cycle, because every strobe is decoded directly from the state and `busy` separates idle from all other states. If the miss-origin flag is lost, a load stops after its fill: `busy` drops one cycle after `cache_wr_en` instead of staying high for a second probe. A wrong latency count makes the memory enable fall too early or stay high too long, and the bench measures this against `MEM_LAT` while it sweeps how long `mem_ready` is held back. Requests raised while the block is busy would show up as stray `tmp_load` or `mem_wr_en` pulses.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_LOOKUP  = 3'd1,
      ST_COHWAIT = 3'd2,
      ST_MEMRD   = 3'd3,
      ST_MEMWR   = 3'd4,
      ST_FILL    = 3'd5
   } seq_state_e;
endpackage

// File: rtl/cseq_lat_timer.sv
module cseq_lat_timer #(
   parameter int MEM_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic done
);
   localparam int CNT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MEM_LAT - 1);

   initial begin
      if (MEM_LAT < 1) $fatal(1, "MEM_LAT must be at least 1");
   end

   generate
      if (MEM_LAT == 1) begin : g_nowait
         assign done = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !active) cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end
         assign done = active && (cnt_q == LAST);
      end
   endgenerate

   // R5
   min_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(done));
endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
   import cseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_write,
   input  logic       cache_hit,
   input  logic       coh_done,
   input  logic       mem_done,
   output seq_state_e state,
   output logic       miss_org
);
   seq_state_e state_d;
   logic       miss_d;

   always_comb begin
      state_d = state;
      miss_d  = miss_org;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) state_d = req_write ? ST_MEMWR : ST_LOOKUP;
         end
         ST_LOOKUP: begin
            if (cache_hit) begin
               state_d = ST_IDLE;
            end else begin
               state_d = ST_COHWAIT;
               miss_d  = 1'b1;
            end
         end
         ST_COHWAIT: if (coh_done) state_d = ST_MEMRD;
         ST_MEMRD:   if (mem_done) state_d = ST_FILL;
         ST_MEMWR:   if (mem_done) state_d = ST_FILL;
         ST_FILL: begin
            state_d = miss_org ? ST_LOOKUP : ST_IDLE;
            miss_d  = 1'b0;
         end
         default: begin
            state_d = ST_IDLE;
            miss_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         miss_org <= 1'b0;
      end else begin
         state    <= state_d;
         miss_org <= miss_d;
      end
   end

   // R4
   coh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COHWAIT && !coh_done) |=> (state == ST_COHWAIT));
endmodule

// File: rtl/cseq_out_decode.sv
module cseq_out_decode
   import cseq_pkg::*;
(
   input  seq_state_e state,
   input  logic       req_valid,
   input  logic       req_write,
   input  logic       cache_hit,
   input  logic       mem_done,
   output logic       mem_rd_en,
   output logic       mem_wr_en,
   output logic       cache_wr_en,
   output logic       tmp_load,
   output logic       read_miss,
   output logic       busy,
   output logic       data_valid
);
   always_comb begin
      busy        = (state != ST_IDLE);
      data_valid  = (state == ST_LOOKUP) && cache_hit;
      read_miss   = (state == ST_LOOKUP) && !cache_hit;
      mem_rd_en   = (state == ST_MEMRD);
      mem_wr_en   = (state == ST_MEMWR);
      cache_wr_en = (state == ST_FILL);
      tmp_load    = ((state == ST_IDLE) && req_valid && req_write) ||
                    ((state == ST_MEMRD) && mem_done);
   end
endmodule

// File: rtl/cache_seq_ctrl.sv
module cache_seq_ctrl
   import cseq_pkg::*;
#(
   parameter int MEM_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic cache_hit,
   input  logic coh_done,
   input  logic mem_ready,
   output logic mem_rd_en,
   output logic mem_wr_en,
   output logic cache_wr_en,
   output logic tmp_load,
   output logic read_miss,
   output logic busy,
   output logic data_valid
);
   seq_state_e state;
   logic       miss_org;
   logic       mem_active;
   logic       lat_done;
   logic       mem_done;

   assign mem_active = (state == ST_MEMRD) || (state == ST_MEMWR);
   assign mem_done   = lat_done && mem_ready;

   cseq_lat_timer #(.MEM_LAT(MEM_LAT)) u_timer (
      .clk(clk), .rst_n(rst_n), .active(mem_active), .done(lat_done)
   );

   cseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .cache_hit(cache_hit), .coh_done(coh_done), .mem_done(mem_done),
      .state(state), .miss_org(miss_org)
   );

   cseq_out_decode u_dec (
      .state(state), .req_valid(req_valid), .req_write(req_write),
      .cache_hit(cache_hit), .mem_done(mem_done),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .cache_wr_en(cache_wr_en),
      .tmp_load(tmp_load), .read_miss(read_miss), .busy(busy),
      .data_valid(data_valid)
   );

   // R6
   read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && tmp_load) |=> cache_wr_en);
   // R8
   miss_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_wr_en && miss_org) |=> busy);
   // R7
   write_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_wr_en && !miss_org) |=> !busy);
   // R4
   miss_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      read_miss |=> (!mem_rd_en && !mem_wr_en));
endmodule

// File: tb/tb_cache_seq_ctrl.sv
module tb_cache_seq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, cache_hit = 1'b0;
   logic coh_done = 1'b0, mem_ready = 1'b0;
   logic mem_rd_en, mem_wr_en, cache_wr_en, tmp_load, read_miss, busy, data_valid;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cache_seq_ctrl #(.MEM_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .cache_hit(cache_hit), .coh_done(coh_done), .mem_ready(mem_ready),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .cache_wr_en(cache_wr_en),
      .tmp_load(tmp_load), .read_miss(read_miss), .busy(busy),
      .data_valid(data_valid)
   );

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #1;
   endtask

   // load; first_hit selects the fast path; noisy raises req_valid while busy
   task automatic run_read(input bit first_hit, input int coh_wait,
                           input int rdy_wait, input bit noisy);
      int dwell;
      bit fin;
      req_valid = 1'b1; req_write = 1'b0; cache_hit = 1'b0;
      settle();
      chk(busy, 0, "R10 idle");
      chk(tmp_load, 0, "R2 load accept no tmp_load");
      tick();
      req_valid = noisy; req_write = noisy;
      cache_hit = first_hit;
      settle();
      chk(busy, 1, "R10 probe");
      chk(data_valid, first_hit, "R3 data_valid");
      chk(read_miss, !first_hit, "R4 read_miss");
      chk(tmp_load, 0, "R9 no tmp_load in probe");
      if (first_hit) begin
         tick();
         req_valid = 1'b0; req_write = 1'b0; cache_hit = 1'b0;
         settle();
         chk(busy, 0, "R3 idle after hit");
         return;
      end
      tick();
      cache_hit = 1'b0;
      for (int c = 0; c < coh_wait; c++) begin
         settle();
         chk(mem_rd_en | mem_wr_en, 0, "R4 no memory before coh_done");
         chk(busy, 1, "R10 coh wait");
         tick();
      end
      coh_done = 1'b1;
      settle();
      chk(mem_rd_en, 0, "R4 no read in coh_done cycle");
      tick();
      coh_done = 1'b0;
      dwell = 0;
      fin = 1'b0;
      for (int k = 0; k < 20 && !fin; k++) begin
         mem_ready = (k >= rdy_wait);
         settle();
         chk(mem_rd_en, 1, "R5 read enable held");
         chk(mem_wr_en, 0, "R9 no write during load");
         fin = (k >= LAT - 1) && (k >= rdy_wait);
         chk(tmp_load, fin, "R6 tmp_load at read end");
         dwell++;
         tick();
      end
      mem_ready = 1'b0;
      chk(dwell, ((LAT - 1 > rdy_wait) ? LAT - 1 : rdy_wait) + 1, "R5 read dwell");
      req_valid = 1'b0; req_write = 1'b0;
      settle();
      chk(mem_rd_en, 0, "R5 read enable dropped");
      chk(cache_wr_en, 1, "R6 fill after read");
      chk(tmp_load, 0, "R9 no tmp_load in fill");
      tick();
      cache_hit = 1'b1;
      settle();
      chk(busy, 1, "R8 back to probe");
      chk(data_valid, 1, "R8 hit after fill");
      tick();
      cache_hit = 1'b0;
      settle();
      chk(busy, 0, "R10 idle after load");
   endtask

   task automatic run_write(input int rdy_wait);
      int dwell;
      bit fin;
      req_valid = 1'b1; req_write = 1'b1;
      settle();
      chk(tmp_load, 1, "R2 store accept tmp_load");
      chk(busy, 0, "R10 idle at store accept");
      tick();
      req_valid = 1'b0; req_write = 1'b0;
      dwell = 0;
      fin = 1'b0;
      for (int k = 0; k < 20 && !fin; k++) begin
         mem_ready = (k >= rdy_wait);
         settle();
         chk(mem_wr_en, 1, "R2 write enable");
         chk(mem_rd_en, 0, "R7 no read during store");
         fin = (k >= LAT - 1) && (k >= rdy_wait);
         dwell++;
         tick();
      end
      mem_ready = 1'b0;
      chk(dwell, ((LAT - 1 > rdy_wait) ? LAT - 1 : rdy_wait) + 1, "R5 write dwell");
      cache_hit = 1'b1;
      settle();
      chk(mem_wr_en, 0, "R5 write enable dropped");
      chk(cache_wr_en, 1, "R7 fill after write");
      chk(tmp_load, 0, "R7 no tmp_load in store fill");
      tick();
      settle();
      chk(busy, 0, "R7 idle after store");
      chk(data_valid, 0, "R7 no data_valid after store");
      cache_hit = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy | data_valid | read_miss | mem_rd_en | mem_wr_en | cache_wr_en | tmp_load,
          0, "R1 reset outputs");
      rst_n = 1'b1;
      tick();
      settle();
      chk(busy, 0, "R1 idle after reset");
      for (int h = 0; h < 2; h++)
         for (int c = 0; c < 3; c++)
            for (int r = 0; r < 6; r++)
               run_read(h[0], c, r, (r % 2) == 1);
      for (int r = 0; r < 6; r++) run_write(r);
      run_write(0);
      run_read(1'b0, 1, 0, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule